// File: doc/BRIEF.md
# Configuration Command Stream Parser

This block sits on the byte path that carries an FPGA configuration image into a device. It accepts one byte per handshake, ignores everything until a fixed 32-bit synchronisation word has gone by, and then splits the stream into control commands. Each command is an opcode byte, three info bytes and a payload whose length depends on the opcode. The block reports every finished command with a one-cycle strobe, the opcode, and the captured payload. It also keeps a running CRC16 over the command bytes and compares it against a check word wherever a command asks for one.

The parser stops accepting bytes once its work is over. That happens on the end-of-image opcode, on an opcode that introduces frame data (a strobe hands the rest of the stream to a frame loader), and on an opcode it does not recognise. Only a reset starts a new image.

Top module: `cfg_cmd_parser`

## Requirements
- R1: After reset, every byte is dropped without effect until the last four accepted bytes, oldest first, read FF FF BD B3. From the next byte on, `synced` is 1 and bytes are parsed as commands. Before that point, no opcode value can raise a strobe or set `done`.
- R2: A byte of value 0xFF in opcode position is padding. It raises no strobe, reads no info bytes and leaves the CRC unchanged.
- R3: A command is one opcode byte, then three info bytes, then its payload. Opcodes 0x3B, 0x46, 0xCE and 0x5E carry no payload. Opcodes 0xE2, 0x22, 0xB4 and 0xC2 carry four bytes, which form `cmd_word` with the first byte in bits 31:24. In the cycle after the last byte of a command is accepted (the payload byte, or the second check byte), `cmd_strobe` is 1 for one cycle and `cmd_op` holds the opcode.
- R4: Opcode 0x02 carries eight bytes, which appear on `dict_bytes` with the first byte in bits 63:56.
- R5: The CRC16 uses polynomial 0x8005, starts at 0x0000, processes each byte MSB first with no reflection and no final XOR, and covers only the opcode, info and payload bytes of commands.
- R6: When bit 7 of the first info byte is 1, two check bytes follow the payload, high byte first. If they differ from the CRC of the bytes before them, `crc_err` goes to 1 and stays there until reset. After every check the CRC restarts from 0x0000.
- R7: A command without a check byte leaves the CRC running into the next command. Opcode 0x3B clears the CRC to 0x0000 at its end.
- R8: At the end of opcode 0xE2, the four-byte payload is compared with `dev_id`. On a mismatch, `id_mismatch` goes to 1 and stays there until reset.
- R9: At the end of opcode 0x5E, `done` goes to 1 and `in_ready` goes to 0. Both hold until reset.
- R10: When opcode 0x82 or 0xB8 is accepted, `frame_go` is 1 for the next cycle only, and `in_ready` is 0 from then on.
- R11: Any opcode not listed in R2, R3, R4 or R10 sets `unknown_err` and drops `in_ready`. Both hold until reset.
- R12: During and just after reset, `in_ready` is 1 and `synced`, `cmd_strobe`, `frame_go`, `done`, `crc_err`, `id_mismatch` and `unknown_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Parser can take a byte |
| dev_id | input | 32 | Expected device identity |
| synced | output | 1 | Synchronisation word has been seen |
| cmd_strobe | output | 1 | One-cycle pulse when a command completes |
| cmd_op | output | 8 | Opcode of the last command |
| cmd_word | output | 32 | Four-byte payload of the last such command |
| dict_bytes | output | 64 | Eight-byte payload of the dictionary command |
| frame_go | output | 1 | One-cycle pulse that hands frame data to a downstream loader |
| done | output | 1 | End of image reached |
| crc_err | output | 1 | Sticky check-word mismatch |
| id_mismatch | output | 1 | Sticky device identity mismatch |
| unknown_err | output | 1 | Sticky unrecognised opcode |

## Verification
The assertions assume that the source holds a byte steady until it is taken, and that every command lasts at least four bytes. Because of the second point, two command strobes can never fall on consecutive cycles. The bench keeps `in_valid` raised until `in_ready` is seen high at an edge, and it always sends a whole command. It never offers a byte after a halting opcode, so every byte it sends is eventually taken.

// File: rtl/cfg_cmd_parser.sv
module cfg_cmd_parser #(
  parameter logic [31:0] SYNC_WORD = 32'hFFFF_BDB3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  input  logic [31:0] dev_id,
  output logic        synced,
  output logic        cmd_strobe,
  output logic [7:0]  cmd_op,
  output logic [31:0] cmd_word,
  output logic [63:0] dict_bytes,
  output logic        frame_go,
  output logic        done,
  output logic        crc_err,
  output logic        id_mismatch,
  output logic        unknown_err
);

  typedef enum logic [2:0] {S_HUNT, S_OP, S_INFO, S_PAY, S_CHK, S_HALT} st_t;

  st_t         st;
  logic [31:0] hunt_sr;
  logic [7:0]  op_q;
  logic        chk_q;
  logic [3:0]  cnt;
  logic [15:0] crc_q;
  logic [7:0]  chk_hi;
  logic [31:0] word_q;
  logic [63:0] dict_q;

  function automatic logic [3:0] pay_len(input logic [7:0] op);
    case (op)
      8'hE2, 8'h22, 8'hB4, 8'hC2: pay_len = 4'd4;
      8'h02:                      pay_len = 4'd8;
      default:                    pay_len = 4'd0;
    endcase
  endfunction

  function automatic logic is_cmd(input logic [7:0] op);
    case (op)
      8'h3B, 8'h46, 8'hCE, 8'h5E, 8'hE2, 8'h22, 8'hB4, 8'hC2, 8'h02: is_cmd = 1'b1;
      default: is_cmd = 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h8005;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  logic        acc;
  logic [15:0] crc_in;
  logic [3:0]  plen;
  logic [31:0] word_nx;
  logic        cmd_end;

  assign in_ready = (st != S_HALT);
  assign acc      = in_valid & in_ready;
  assign crc_in   = crc_step(crc_q, in_data);
  assign plen     = pay_len(op_q);
  assign word_nx  = (st == S_PAY) ? {word_q[23:0], in_data} : word_q;

  always_comb begin
    cmd_end = 1'b0;
    if (acc) begin
      case (st)
        S_INFO:  cmd_end = (cnt == 4'd2) && (plen == 4'd0) && !chk_q;
        S_PAY:   cmd_end = (cnt == plen - 4'd1) && !chk_q;
        S_CHK:   cmd_end = (cnt == 4'd1);
        default: cmd_end = 1'b0;
      endcase
    end
  end

  assign cmd_op     = op_q;
  assign cmd_word   = word_q;
  assign dict_bytes = dict_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_HUNT;
      hunt_sr     <= '0;
      op_q        <= '0;
      chk_q       <= 1'b0;
      cnt         <= '0;
      crc_q       <= '0;
      chk_hi      <= '0;
      word_q      <= '0;
      dict_q      <= '0;
      synced      <= 1'b0;
      cmd_strobe  <= 1'b0;
      frame_go    <= 1'b0;
      done        <= 1'b0;
      crc_err     <= 1'b0;
      id_mismatch <= 1'b0;
      unknown_err <= 1'b0;
    end else begin
      cmd_strobe <= 1'b0;
      frame_go   <= 1'b0;
      if (acc) begin
        case (st)
          S_HUNT: begin
            hunt_sr <= {hunt_sr[23:0], in_data};
            if ({hunt_sr[23:0], in_data} == SYNC_WORD) begin
              st     <= S_OP;
              synced <= 1'b1;
            end
          end
          S_OP: begin
            if (in_data != 8'hFF) begin
              op_q <= in_data;
              cnt  <= '0;
              if (is_cmd(in_data)) begin
                crc_q <= crc_in;
                st    <= S_INFO;
              end else if (in_data == 8'h82 || in_data == 8'hB8) begin
                frame_go <= 1'b1;
                st       <= S_HALT;
              end else begin
                unknown_err <= 1'b1;
                st          <= S_HALT;
              end
            end
          end
          S_INFO: begin
            crc_q <= crc_in;
            cnt   <= cnt + 4'd1;
            if (cnt == 4'd0) chk_q <= in_data[7];
            if (cnt == 4'd2) begin
              cnt <= '0;
              if (plen != 4'd0) st <= S_PAY;
              else if (chk_q)   st <= S_CHK;
              else              st <= S_OP;
            end
          end
          S_PAY: begin
            crc_q <= crc_in;
            cnt   <= cnt + 4'd1;
            if (plen == 4'd8) dict_q <= {dict_q[55:0], in_data};
            else              word_q <= word_nx;
            if (cnt == plen - 4'd1) begin
              cnt <= '0;
              st  <= chk_q ? S_CHK : S_OP;
            end
          end
          S_CHK: begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd0) chk_hi <= in_data;
            else begin
              cnt   <= '0;
              crc_q <= '0;
              if ({chk_hi, in_data} != crc_q) crc_err <= 1'b1;
              st <= S_OP;
            end
          end
          default: ;
        endcase
      end
      if (cmd_end) begin
        cmd_strobe <= 1'b1;
        if (op_q == 8'h3B) crc_q <= '0;
        if (op_q == 8'hE2 && word_nx != dev_id) id_mismatch <= 1'b1;
        if (op_q == 8'h5E) begin
          done <= 1'b1;
          st   <= S_HALT;
        end
      end
    end
  end

endmodule

module cfg_cmd_parser_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic synced,
  input logic cmd_strobe,
  input logic frame_go,
  input logic done,
  input logic crc_err,
  input logic id_mismatch,
  input logic unknown_err
);
  AST_NO_STROBE_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n) !synced |-> !cmd_strobe); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_strobe |=> !cmd_strobe); // R3
  AST_CRC_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) crc_err |=> crc_err); // R6
  AST_ID_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) id_mismatch |=> id_mismatch); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R9
  AST_DONE_HALTS: assert property (@(posedge clk) disable iff (!rst_n) done |-> !in_ready); // R9
  AST_HANDOFF_PULSE: assert property (@(posedge clk) disable iff (!rst_n) frame_go |=> (!frame_go && !in_ready)); // R10
  AST_UNKNOWN_HALTS: assert property (@(posedge clk) disable iff (!rst_n) unknown_err |-> !in_ready); // R11
endmodule

bind cfg_cmd_parser cfg_cmd_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .synced(synced),
  .cmd_strobe(cmd_strobe), .frame_go(frame_go), .done(done),
  .crc_err(crc_err), .id_mismatch(id_mismatch), .unknown_err(unknown_err)
);

// File: tb/sim_cfg_cmd_parser.sv
module sim_cfg_cmd_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic [31:0] dev_id = 32'h4111_2043;
  logic        synced, cmd_strobe, frame_go, done, crc_err, id_mismatch, unknown_err;
  logic [7:0]  cmd_op;
  logic [31:0] cmd_word;
  logic [63:0] dict_bytes;

  int n_run = 0, n_fail = 0, n_strobe = 0;
  logic [15:0] mcrc = '0;

  always #5 clk = ~clk;

  cfg_cmd_parser u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .dev_id(dev_id), .synced(synced), .cmd_strobe(cmd_strobe), .cmd_op(cmd_op),
    .cmd_word(cmd_word), .dict_bytes(dict_bytes), .frame_go(frame_go), .done(done),
    .crc_err(crc_err), .id_mismatch(id_mismatch), .unknown_err(unknown_err)
  );

  always @(posedge clk) if (rst_n && cmd_strobe) n_strobe++;

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h8005) : (r << 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_data = b;
    in_valid = 1'b1;
    @(posedge clk);
    while (!in_ready) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_c(input logic [7:0] b);
    mcrc = crc_ref(mcrc, b);
    send(b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    mcrc = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sync_up();
    send(8'hFF); send(8'hFF); send(8'hBD); send(8'hB3);
  endtask

  task automatic command(input logic [7:0] op, input logic chk, input int n,
                         input logic [63:0] pl, input logic good);
    logic [15:0] cv;
    send_c(op);
    send_c({chk, 7'd0}); send_c(8'h00); send_c(8'h00);
    for (int i = 0; i < n; i++) send_c(8'(pl >> (8 * (n - 1 - i))));
    if (chk) begin
      cv = good ? mcrc : ~mcrc;
      send(cv[15:8]); send(cv[7:0]);
      mcrc = '0;
    end
    if (op == 8'h3B) mcrc = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int base;
    logic [3:0] plen;
    do_reset();
    check("R12 ready", in_ready, 1);
    check("R12 flags", {synced, cmd_strobe, frame_go, done, crc_err, id_mismatch, unknown_err}, 0);

    // R1: metadata, a would-be end opcode and a partial sync word are all dropped
    send(8'hFF); send(8'h00); send(8'h41); send(8'h00); send(8'h00); send(8'hFF);
    send(8'h5E); send(8'h00); send(8'h00); send(8'h00);
    send(8'hFF); send(8'hFF); send(8'hBD); send(8'h00);
    check("R1 unsynced", synced, 0);
    check("R1 no strobe", n_strobe, 0);
    check("R1 no done", done, 0);
    sync_up();
    check("R1 synced", synced, 1);

    // R2: padding
    send(8'hFF); send(8'hFF); send(8'hFF);
    check("R2 pad no strobe", n_strobe, 0);
    check("R2 pad ready", in_ready, 1);

    command(8'h3B, 0, 0, 0, 1);
    check("R3 reset cmd strobe", cmd_strobe, 1);
    check("R3 reset cmd op", cmd_op, 8'h3B);
    command(8'hE2, 0, 4, 64'h4111_2043, 1);
    check("R3 id word", cmd_word, 32'h4111_2043);
    check("R8 id match", id_mismatch, 0);
    send(8'hFF);
    command(8'h22, 1, 4, 64'h4000_0000, 1);
    check("R3 ctrl word", cmd_word, 32'h4000_0000);
    check("R7 crc spans commands", crc_err, 0);
    command(8'h02, 1, 8, 64'h0123_4567_89AB_CDEF, 1);
    check("R4 dict", dict_bytes, 64'h0123_4567_89AB_CDEF);
    check("R5 crc dict", crc_err, 0);
    command(8'hB4, 0, 4, 64'hDEAD_BEEF, 1);
    command(8'h3B, 0, 0, 0, 1);
    command(8'hC2, 1, 4, 64'h1234_5678, 1);
    check("R7 crc cleared by 3B", crc_err, 0);
    check("R3 user word", cmd_word, 32'h1234_5678);
    command(8'hE2, 0, 4, 64'h0111_2043, 1);
    check("R8 id mismatch", id_mismatch, 1);
    command(8'h5E, 0, 0, 0, 1);
    check("R9 done", done, 1);
    check("R9 halted", in_ready, 0);

    do_reset();
    sync_up();
    command(8'h46, 1, 0, 0, 0);
    check("R6 bad check", crc_err, 1);
    command(8'hCE, 1, 0, 0, 1);
    check("R6 sticky", crc_err, 1);

    // opcode sweep: R3 R9 R10 R11
    for (int op = 0; op < 255; op++) begin
      do_reset();
      sync_up();
      base = n_strobe;
      if (op == 8'h82 || op == 8'hB8) begin
        send(8'(op));
        check("R10 handoff pulse", frame_go, 1);
        check("R10 handoff halt", in_ready, 0);
        @(negedge clk);
        check("R10 pulse ends", frame_go, 0);
      end else if (op == 8'h3B || op == 8'h46 || op == 8'hCE || op == 8'h5E ||
                   op == 8'hE2 || op == 8'h22 || op == 8'hB4 || op == 8'hC2 || op == 8'h02) begin
        plen = (op == 8'h02) ? 4'd8 : ((op == 8'hE2 || op == 8'h22 || op == 8'hB4 || op == 8'hC2) ? 4'd4 : 4'd0);
        command(8'(op), 0, int'(plen), 64'h0, 1);
        check("R3 sweep strobe", {cmd_strobe, cmd_op}, {1'b1, 8'(op)});
        check("R9 sweep done", {done, in_ready}, (op == 8'h5E) ? 2'b10 : 2'b01);
        check("R11 sweep known", unknown_err, 0);
      end else begin
        send(8'(op));
        check("R11 unknown", {unknown_err, in_ready, frame_go}, 3'b100);
        check("R11 no strobe", n_strobe - base, 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule